// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block produces word addresses for indirect data accesses. It keeps a bank of eight 16-bit pointer registers, and each pointer has a 7-bit extension. For every access the block puts out a 23-bit word address. The address is the extension of the selected pointer joined above the pointer value as it stood before the access. In the same clock edge the block writes a post-modified value back into that pointer, so pointer arithmetic costs no extra cycle.

The caller gives a pointer index, a 3-bit post-modify code and a signed step value. A circular buffer is described by a base address and a length. The available post-modifications are: hold, add one, subtract one, add the step, step with wrap inside the circular buffer, and step with the carry running from the most significant bit down, which walks a buffer in bit-reversed order. A separate load port writes a pointer. A wide load sets the pointer and its extension together. A narrow load sets only the pointer.

Top module: `ptr_addr_gen`

## Requirements
- R1: After a synchronous active-low reset every pointer and every extension is zero, so an access to any pointer returns address 0.
- R2: While `acc_en` is high, `addr_out` equals {extension, pointer} of the pointer chosen by `acc_sel`, taken before that cycle's update. `addr_vld` follows `acc_en` in the same cycle.
- R3: Mode code 0 (hold) leaves the selected pointer unchanged. Codes 6 and 7 behave the same way.
- R4: Code 1 adds one to the pointer and code 2 subtracts one. Both wrap modulo 2^16.
- R5: Code 3 adds `acc_step`, read as a two's-complement value, modulo 2^16.
- R6: Code 4 moves the pointer by the signed `acc_step` inside the region from `circ_base` to `circ_base + circ_len - 1`. A move past either end wraps to the other end. This assumes the pointer lies in the region and the step magnitude is at most `circ_len`.
- R7: Code 5 adds `acc_step` with the carry propagating from bit 15 toward bit 0. For example, a step of 4 from pointer 0x0100 visits 0x0100, 0x0104, 0x0102, 0x0106, 0x0101, 0x0105, 0x0103, 0x0107 and then returns to 0x0100.
- R8: A wide load (`ld_wide`=1) writes `ld_data[15:0]` to the pointer and `ld_data[22:16]` to its extension. A narrow load writes only `ld_data[15:0]` and keeps the extension.
- R9: When a load and a post-update target the same pointer in one cycle, the loaded value is kept.
- R10: A load and a post-update that target different pointers in one cycle both take effect.
- R11: No post-update changes an extension. A carry or borrow out of bit 15 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_sel | input | 3 | Pointer used by the access |
| acc_mode | input | 3 | Post-modify code (0 hold, 1 inc, 2 dec, 3 index, 4 circular, 5 reverse-carry) |
| acc_step | input | 16 | Signed step or index value |
| circ_base | input | 16 | First address of the circular region |
| circ_len | input | 16 | Length of the circular region in words |
| ld_en | input | 1 | Pointer load request |
| ld_sel | input | 3 | Pointer to load |
| ld_wide | input | 1 | 1: load pointer and extension; 0: pointer only |
| ld_data | input | 23 | Load value; bits 22:16 go to the extension on a wide load |
| addr_out | output | 23 | Word address of the access |
| addr_vld | output | 1 | Address valid |

## Verification
The assertions watch several properties on every cycle. A load always wins at the following edge, and a narrow load leaves the extension intact. A circular step that starts inside the region stays inside it. An increment on a pointer shows up as address plus one when that pointer is accessed again in the next cycle. The directed scenarios cover the rest: the exact bit-reversed visiting order, the wrap points of circular stepping in both directions, wrap at the 16-bit boundary without a carry into the extension, and the handling of unused mode codes. Only known sequences of accesses and loads can show these.

// File: rtl/ptr_agu_pkg.sv
// Shared widths and post-modify codes for the pointer address generator.
// Assumes the code values are fixed; the decoder depends on them.
package ptr_agu_pkg;
    typedef enum logic [2:0] {
        PM_HOLD  = 3'd0,
        PM_INC   = 3'd1,
        PM_DEC   = 3'd2,
        PM_INDEX = 3'd3,
        PM_CIRC  = 3'd4,
        PM_REV   = 3'd5
    } pmode_e;
endpackage

// File: rtl/ptr_circ_wrap.sv
// Circular step: moves a pointer by a signed step inside [base, base+len-1].
// Assumes the pointer starts inside the region and |step| <= len.
module ptr_circ_wrap #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic [PW-1:0] cur,
    input  logic [PW-1:0] step,
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] len,
    output logic [PW-1:0] nxt
);
    localparam int XW = PW + 2;

    logic [XW-1:0] off_x, step_x, len_x, sum_x, wrap_x;

    // Offset inside region, signed sum, then one correction step.
    always_comb begin
        off_x  = {2'b00, cur - base};
        step_x = {{2{step[PW-1]}}, step};
        len_x  = {2'b00, len};
        sum_x  = off_x + step_x;
        if (sum_x[XW-1])
            wrap_x = sum_x + len_x;
        else if (sum_x >= len_x)
            wrap_x = sum_x - len_x;
        else
            wrap_x = sum_x;
        nxt = base + wrap_x[PW-1:0];
    end

    logic [PW-1:0] step_mag;
    logic          pre_ok;
    // Magnitude of step and range precondition for the check below.
    always_comb begin
        step_mag = step[PW-1] ? (~step + 1'b1) : step;
        pre_ok   = ((cur - base) < len) && (step_mag <= len) && !step_mag[PW-1];
    end

    // R6
    circ_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && pre_ok) |-> ((nxt - base) < len));
endmodule

// File: rtl/ptr_revcarry_add.sv
// Reverse-carry adder: sum of a and b with carry moving from MSB to LSB.
// Built by bit-reversing both operands, adding, and reversing the sum.
module ptr_revcarry_add #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    output logic [PW-1:0] sum
);
    logic [PW-1:0] ra, rb, rs;

    for (genvar i = 0; i < PW; i++) begin : g_rev
        assign ra[i]  = a[PW-1-i];
        assign rb[i]  = b[PW-1-i];
        assign sum[i] = rs[PW-1-i];
    end

    assign rs = ra + rb;
endmodule

// File: rtl/ptr_step_unit.sv
// Post-modify arithmetic: picks the next pointer value from the mode code.
// Assumes unused codes mean hold; chg flags a value that differs by mode.
module ptr_step_unit
    import ptr_agu_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic [2:0]    mode,
    input  logic [PW-1:0] cur,
    input  logic [PW-1:0] step,
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] len,
    output logic [PW-1:0] nxt,
    output logic          chg
);
    logic [PW-1:0] circ_nxt, rev_nxt;

    ptr_circ_wrap #(.PW(PW)) u_circ (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (act && (mode == PM_CIRC)),
        .cur  (cur),
        .step (step),
        .base (base),
        .len  (len),
        .nxt  (circ_nxt)
    );

    ptr_revcarry_add #(.PW(PW)) u_rev (
        .a  (cur),
        .b  (step),
        .sum(rev_nxt)
    );

    // Mode decode into next pointer value.
    always_comb begin
        chg = 1'b1;
        unique case (mode)
            PM_INC:   nxt = cur + 1'b1;
            PM_DEC:   nxt = cur - 1'b1;
            PM_INDEX: nxt = cur + step;
            PM_CIRC:  nxt = circ_nxt;
            PM_REV:   nxt = rev_nxt;
            default: begin
                nxt = cur;
                chg = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ptr_bank.sv
// Pointer register bank with per-pointer extensions.
// One read port, one post-update write, one load write; load has priority.
module ptr_bank #(
    parameter int NPTR = 8,
    parameter int PW   = 16,
    parameter int EW   = 7,
    localparam int SW  = $clog2(NPTR),
    localparam int AW  = PW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_sel,
    output logic [PW-1:0] rd_ptr,
    output logic [EW-1:0] rd_ext,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [PW-1:0] upd_val,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic          ld_wide,
    input  logic [AW-1:0] ld_val
);
    logic [PW-1:0] ptr_q [NPTR];
    logic [EW-1:0] ext_q [NPTR];

    for (genvar i = 0; i < NPTR; i++) begin : g_reg
        // Pointer register: load first, then post-update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[i] <= '0;
            else if (ld_en && (ld_sel == SW'(i)))
                ptr_q[i] <= ld_val[PW-1:0];
            else if (upd_en && (upd_sel == SW'(i)))
                ptr_q[i] <= upd_val;
        end

        // Extension register: written only by a wide load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_q[i] <= '0;
            else if (ld_en && ld_wide && (ld_sel == SW'(i)))
                ext_q[i] <= ld_val[AW-1:PW];
        end
    end

    assign rd_ptr = ptr_q[rd_sel];
    assign rd_ext = ext_q[rd_sel];

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ptr_q[$past(ld_sel)] == $past(ld_val[PW-1:0])));

    // R8
    narrow_keeps_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !ld_wide) |=> (ext_q[$past(ld_sel)] == $past(ext_q[ld_sel])));

    // R11
    upd_keeps_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(ld_en && ld_sel == upd_sel)) |=>
            (ext_q[$past(upd_sel)] == $past(ext_q[upd_sel])));
endmodule

// File: rtl/ptr_addr_gen.sv
// Top: issues {extension, pointer} as the access address and writes the
// post-modified pointer back at the same edge. Assumes one access per cycle.
module ptr_addr_gen #(
    parameter int NPTR = 8,
    parameter int PW   = 16,
    parameter int EW   = 7,
    localparam int SW  = $clog2(NPTR),
    localparam int AW  = PW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [SW-1:0] acc_sel,
    input  logic [2:0]    acc_mode,
    input  logic [PW-1:0] acc_step,
    input  logic [PW-1:0] circ_base,
    input  logic [PW-1:0] circ_len,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic          ld_wide,
    input  logic [AW-1:0] ld_data,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);
    import ptr_agu_pkg::*;

    logic [PW-1:0] cur_ptr, nxt_ptr;
    logic [EW-1:0] cur_ext;
    logic          step_chg;

    ptr_bank #(.NPTR(NPTR), .PW(PW), .EW(EW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_sel (acc_sel),
        .rd_ptr (cur_ptr),
        .rd_ext (cur_ext),
        .upd_en (acc_en && step_chg),
        .upd_sel(acc_sel),
        .upd_val(nxt_ptr),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_wide(ld_wide),
        .ld_val (ld_data)
    );

    ptr_step_unit #(.PW(PW)) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (acc_en),
        .mode (acc_mode),
        .cur  (cur_ptr),
        .step (acc_step),
        .base (circ_base),
        .len  (circ_len),
        .nxt  (nxt_ptr),
        .chg  (step_chg)
    );

    assign addr_out = {cur_ext, cur_ptr};
    assign addr_vld = acc_en;

    // R4
    inc_then_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && $past(acc_en) && $past(acc_mode) == PM_INC &&
         acc_sel == $past(acc_sel) &&
         !($past(ld_en) && $past(ld_sel) == $past(acc_sel)))
        |-> (addr_out[PW-1:0] == PW'($past(addr_out[PW-1:0]) + 1'b1)));

    // R2
    ext_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && $past(acc_en) && acc_sel == $past(acc_sel) && !$past(ld_en))
        |-> (addr_out[AW-1:PW] == $past(addr_out[AW-1:PW])));
endmodule

// File: tb/ptr_addr_gen_tb.sv
module ptr_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [2:0]  acc_mode = '0;
    logic [15:0] acc_step = '0;
    logic [15:0] circ_base = '0;
    logic [15:0] circ_len = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic        ld_wide = 1'b0;
    logic [22:0] ld_data = '0;
    logic [22:0] addr_out;
    logic        addr_vld;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    ptr_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel),
        .acc_mode(acc_mode), .acc_step(acc_step), .circ_base(circ_base),
        .circ_len(circ_len), .ld_en(ld_en), .ld_sel(ld_sel), .ld_wide(ld_wide),
        .ld_data(ld_data), .addr_out(addr_out), .addr_vld(addr_vld)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [22:0] got, input logic [22:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle: drive at negedge, sample address, step past the edge.
    task automatic cyc(input bit a_en, input logic [2:0] a_sel, input logic [2:0] a_mode,
                       input logic [15:0] a_step, input bit l_en, input logic [2:0] l_sel,
                       input bit l_wide, input logic [22:0] l_data, output logic [22:0] a);
        acc_en = a_en; acc_sel = a_sel; acc_mode = a_mode; acc_step = a_step;
        ld_en = l_en; ld_sel = l_sel; ld_wide = l_wide; ld_data = l_data;
        #1 a = addr_out;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; ld_en = 1'b0;
    endtask

    task automatic acc(input logic [2:0] s, input logic [2:0] m, input logic [15:0] st,
                       output logic [22:0] a);
        cyc(1, s, m, st, 0, 0, 0, 0, a);
    endtask

    task automatic load(input logic [2:0] s, input bit w, input logic [22:0] d);
        logic [22:0] a;
        cyc(0, 0, 0, 0, 1, s, w, d, a);
    endtask

    task automatic peek(input logic [2:0] s, output logic [22:0] a);
        acc(s, 3'd0, 16'd0, a);
    endtask

    task automatic t_reset;
        logic [22:0] a;
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), a);
            chk("R1 reset pointer zero", a, 23'h0);
        end
        acc_en = 1'b1; #1;
        chk("R2 addr_vld follows acc_en", {22'd0, addr_vld}, 23'd1);
        acc_en = 1'b0; #1;
        chk("R2 addr_vld low when idle", {22'd0, addr_vld}, 23'd0);
    endtask

    task automatic t_load_and_hold;
        logic [22:0] a;
        load(3'd2, 1, 23'h7F0203);
        peek(3'd2, a);
        chk("R8 wide load sets ext and ptr", a, 23'h7F0203);
        peek(3'd2, a);
        chk("R3 hold keeps pointer", a, 23'h7F0203);
        load(3'd2, 0, 23'h001234);
        peek(3'd2, a);
        chk("R8 narrow load keeps ext", a, 23'h7F1234);
    endtask

    task automatic t_inc_dec;
        logic [22:0] a;
        load(3'd3, 1, 23'h05FFFF);
        acc(3'd3, 3'd1, 16'd0, a);
        chk("R2 pre-update address", a, 23'h05FFFF);
        peek(3'd3, a);
        chk("R4 R11 inc wraps without ext carry", a, 23'h050000);
        acc(3'd3, 3'd2, 16'd0, a);
        peek(3'd3, a);
        chk("R4 R11 dec wraps without ext borrow", a, 23'h05FFFF);
        acc(3'd3, 3'd2, 16'd0, a);
        acc(3'd3, 3'd2, 16'd0, a);
        chk("R4 back-to-back dec", a, 23'h05FFFE);
    endtask

    task automatic t_index;
        logic [22:0] a;
        load(3'd4, 1, 23'h001000);
        acc(3'd4, 3'd3, 16'h0010, a);
        peek(3'd4, a);
        chk("R5 index add positive", a, 23'h001010);
        acc(3'd4, 3'd3, 16'hFFE0, a);
        peek(3'd4, a);
        chk("R5 index add negative", a, 23'h000FF0);
        acc(3'd4, 3'd6, 16'h0010, a);
        acc(3'd4, 3'd7, 16'h0010, a);
        peek(3'd4, a);
        chk("R3 codes 6 and 7 hold", a, 23'h000FF0);
    endtask

    task automatic t_circ;
        logic [22:0] a;
        logic [15:0] exp_seq [5] = '{16'h0203, 16'h0200, 16'h0202, 16'h0204, 16'h0201};
        circ_base = 16'h0200; circ_len = 16'd5;
        load(3'd5, 1, 23'h110203);
        for (int i = 0; i < 5; i++) begin
            acc(3'd5, 3'd4, 16'd2, a);
            chk("R6 circular +2 walk", a, {7'h11, exp_seq[i]});
        end
        peek(3'd5, a);
        chk("R6 circular +2 final", a, 23'h110203);
        acc(3'd5, 3'd4, 16'hFFFC, a);
        peek(3'd5, a);
        chk("R6 circular -4 wraps low", a, 23'h110204);
        acc(3'd5, 3'd4, 16'd5, a);
        peek(3'd5, a);
        chk("R6 circular step equal to length", a, 23'h110204);
    endtask

    task automatic t_rev;
        logic [22:0] a;
        logic [15:0] exp_seq [9] = '{16'h0100, 16'h0104, 16'h0102, 16'h0106,
                                     16'h0101, 16'h0105, 16'h0103, 16'h0107, 16'h0100};
        load(3'd6, 1, 23'h020100);
        for (int i = 0; i < 9; i++) begin
            acc(3'd6, 3'd5, 16'd4, a);
            chk("R7 reverse-carry order", a, {7'h02, exp_seq[i]});
        end
    endtask

    task automatic t_collide;
        logic [22:0] a;
        load(3'd1, 1, 23'h030010);
        cyc(1, 3'd1, 3'd1, 16'd0, 1, 3'd1, 0, 23'h00ABCD, a);
        chk("R2 address during collision", a, 23'h030010);
        peek(3'd1, a);
        chk("R9 load beats update", a, 23'h03ABCD);
        cyc(1, 3'd1, 3'd1, 16'd0, 1, 3'd7, 1, 23'h445566, a);
        peek(3'd1, a);
        chk("R10 update on other pointer", a, 23'h03ABCE);
        peek(3'd7, a);
        chk("R10 load on other pointer", a, 23'h445566);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_and_hold();
        t_inc_dec();
        t_index();
        t_circ();
        t_rev();
        t_collide();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule